// File: doc/BRIEF.md
# Indexed Configuration Probe Sequencer

The block runs the discovery pass for a security coprocessor that can only be reached through an index/data register pair in I/O space. A start pulse launches a fixed series of ten accesses. Each access writes a byte-wide index code to the index port and then reads the selected byte back from the data port. The series collects the coprocessor's 16-bit I/O base address, a four-byte version and a four-byte vendor identifier.

Once the last byte is in, the block issues a done pulse. At the same time it raises either a present flag or an absent flag. The coprocessor counts as absent when either identification read comes back as all ones. Every access on the simple I/O bus holds its strobe until the target signals ready.

After a successful probe, further start pulses do nothing. After a failed probe, the host may start the sequence again.

Top module: `probe_seq`

## Requirements
- R1: The index codes written are 0x08, 0x09, 0x00, 0x01, 0x02, 0x03, 0x04, 0x05, 0x06, 0x07, in that order. Each index write goes to address 0x004E and is followed by exactly one read of address 0x004F before the next index write.
- R2: A write or read strobe stays asserted, with address and write data unchanged, until io_rdy_i is sampled high at a clock edge. The write and read strobes are never active together, and an accepted index write is followed directly by the read strobe.
- R3: base_addr_o[15:8] holds the byte read after index 0x09 and base_addr_o[7:0] holds the byte read after index 0x08.
- R4: version_o[8k+7:8k] holds the byte read after index k, for k = 0..3.
- R5: vendor_o[8k+7:8k] holds the byte read after index 4+k, for k = 0..3.
- R6: present_o is raised only when version byte 0 and vendor byte 0 both differ from 0xFF. Otherwise absent_o is raised. The two flags are never high together.
- R7: done_o is a single-cycle pulse. It is high in the cycle after the last data read is accepted, and the flags take their new values in that same cycle.
- R8: A start pulse while present_o is high causes no bus access and changes no output.
- R9: A start pulse while present_o is low clears absent_o in the next cycle and runs the full sequence again.
- R10: An active-low reset clears base_addr_o, version_o, vendor_o, present_o, absent_o and done_o, and leaves both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for one probe pass |
| io_addr_o | output | 16 | I/O address |
| io_wdata_o | output | 8 | I/O write data (index code) |
| io_wr_o | output | 1 | Write strobe |
| io_rd_o | output | 1 | Read strobe |
| io_rdata_i | input | 8 | I/O read data |
| io_rdy_i | input | 1 | Access accepted in this cycle |
| base_addr_o | output | 16 | Collected base address |
| version_o | output | 32 | Collected version, byte 0 in bits 7:0 |
| vendor_o | output | 32 | Collected vendor identifier, byte 0 in bits 7:0 |
| present_o | output | 1 | Coprocessor found |
| absent_o | output | 1 | Probe finished and an identification read was all ones |
| done_o | output | 1 | One-cycle pulse at the end of a pass |

## Verification
The bound checker watches the bus discipline on every cycle. It covers strobe exclusivity, held strobes with steady address and data, the fixed port address of each strobe, and the read that must follow each write. It also checks that the flags are exclusive, that done is a single pulse which coincides with a decided flag, and that a start while present produces no write. The bench scenarios are the only place to see the exact index order, the mapping of returned bytes onto the base, version and vendor outputs, the all-ones decisions for each identification byte, the retry after a failure and the clearing by reset. A responder with varied wait states serves these scenarios.

// File: rtl/probe_pkg.sv
package probe_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned NUM_STEPS = 10;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  typedef enum logic [1:0] {BUS_IDLE, BUS_WR, BUS_RD} bus_state_e;

  // base bytes first (codes 8,9), then version/vendor codes 0..7
  function automatic logic [BYTE_W-1:0] step_index(input logic [STEP_W-1:0] s);
    logic [BYTE_W-1:0] sx;
    sx = {{(BYTE_W-STEP_W){1'b0}}, s};
    return (sx < 8'd2) ? (sx + 8'd8) : (sx - 8'd2);
  endfunction
endpackage

// File: rtl/probe_bus.sv
module probe_bus
  import probe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h004E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h004F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [BYTE_W-1:0] index_i,
  output logic              idle_o,
  output logic              ack_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [BYTE_W-1:0] io_wdata_o,
  output logic              io_wr_o,
  output logic              io_rd_o,
  input  logic [BYTE_W-1:0] io_rdata_i,
  input  logic              io_rdy_i
);
  bus_state_e state_q, state_d;
  logic [BYTE_W-1:0] idx_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      BUS_IDLE: if (go_i) state_d = BUS_WR;
      BUS_WR:   if (io_rdy_i) state_d = BUS_RD;
      BUS_RD:   if (io_rdy_i) state_d = BUS_IDLE;
      default:  state_d = BUS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BUS_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == BUS_IDLE && go_i) idx_q <= index_i;
    end
  end

  assign idle_o     = (state_q == BUS_IDLE);
  assign io_wr_o    = (state_q == BUS_WR);
  assign io_rd_o    = (state_q == BUS_RD);
  assign io_addr_o  = io_rd_o ? DAT_ADDR : IDX_ADDR;
  assign io_wdata_o = io_wr_o ? idx_q : '0;
  assign ack_o      = io_rd_o && io_rdy_i;
  assign rdata_o    = io_rdata_i;
endmodule

// File: rtl/probe_store.sv
module probe_store
  import probe_pkg::*;
#(
  parameter int unsigned NUM_BYTES = NUM_STEPS,
  localparam int unsigned SEL_W = $clog2(NUM_BYTES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          we_i,
  input  logic [SEL_W-1:0]              sel_i,
  input  logic [BYTE_W-1:0]             byte_i,
  output logic [NUM_BYTES*BYTE_W-1:0]   bytes_o
);
  for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && sel_i == SEL_W'(g)) q <= byte_i;
    end
    assign bytes_o[g*BYTE_W +: BYTE_W] = q;
  end
endmodule

// File: rtl/probe_seq.sv
module probe_seq
  import probe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h004E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h004F
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic [ADDR_W-1:0] io_addr_o,
  output logic [7:0]        io_wdata_o,
  output logic              io_wr_o,
  output logic              io_rd_o,
  input  logic [7:0]        io_rdata_i,
  input  logic              io_rdy_i,
  output logic [15:0]       base_addr_o,
  output logic [31:0]       version_o,
  output logic [31:0]       vendor_o,
  output logic              present_o,
  output logic              absent_o,
  output logic              done_o
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [BYTE_W-1:0] ALL_ONES  = '1;

  logic              run_q, done_q, present_q, absent_q;
  logic [STEP_W-1:0] step_q;
  logic              bus_idle, bus_ack, go;
  logic [BYTE_W-1:0] bus_rdata;
  logic [NUM_STEPS*BYTE_W-1:0] bytes;
  logic              id_ok;

  assign go = run_q && bus_idle;

  probe_bus #(
    .ADDR_W   (ADDR_W),
    .IDX_ADDR (IDX_ADDR),
    .DAT_ADDR (DAT_ADDR)
  ) u_bus (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (go),
    .index_i    (step_index(step_q)),
    .idle_o     (bus_idle),
    .ack_o      (bus_ack),
    .rdata_o    (bus_rdata),
    .io_addr_o  (io_addr_o),
    .io_wdata_o (io_wdata_o),
    .io_wr_o    (io_wr_o),
    .io_rd_o    (io_rd_o),
    .io_rdata_i (io_rdata_i),
    .io_rdy_i   (io_rdy_i)
  );

  probe_store #(.NUM_BYTES(NUM_STEPS)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bus_ack),
    .sel_i   (step_q),
    .byte_i  (bus_rdata),
    .bytes_o (bytes)
  );

  // step 2 holds version byte 0, step 6 vendor byte 0; both stored before the last step
  assign id_ok = (bytes[2*BYTE_W +: BYTE_W] != ALL_ONES) &&
                 (bytes[6*BYTE_W +: BYTE_W] != ALL_ONES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q     <= 1'b0;
      step_q    <= '0;
      done_q    <= 1'b0;
      present_q <= 1'b0;
      absent_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !run_q && !present_q) begin
        run_q    <= 1'b1;
        step_q   <= '0;
        absent_q <= 1'b0;
      end else if (bus_ack) begin
        if (step_q == LAST_STEP) begin
          run_q     <= 1'b0;
          done_q    <= 1'b1;
          present_q <= id_ok;
          absent_q  <= !id_ok;
        end else begin
          step_q <= step_q + 1'b1;
        end
      end
    end
  end

  assign base_addr_o = {bytes[1*BYTE_W +: BYTE_W], bytes[0 +: BYTE_W]};
  assign version_o   = bytes[2*BYTE_W +: 4*BYTE_W];
  assign vendor_o    = bytes[6*BYTE_W +: 4*BYTE_W];
  assign present_o   = present_q;
  assign absent_o    = absent_q;
  assign done_o      = done_q;
endmodule

// File: rtl/probe_seq_chk.sv
module probe_seq_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] IDX_ADDR = 16'h004E,
  parameter logic [ADDR_W-1:0] DAT_ADDR = 16'h004F
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] io_addr_o,
  input logic [7:0]        io_wdata_o,
  input logic              io_wr_o,
  input logic              io_rd_o,
  input logic              io_rdy_i,
  input logic              present_o,
  input logic              absent_o,
  input logic              done_o
);
  assert_strobe_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_o && io_rd_o));
  assert_wr_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o && !io_rdy_i |=> io_wr_o && $stable(io_wdata_o) && $stable(io_addr_o));
  assert_rd_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_o && !io_rdy_i |=> io_rd_o && $stable(io_addr_o));
  assert_wr_then_rd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o && io_rdy_i |=> io_rd_o);
  assert_wr_port_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_wr_o |-> io_addr_o == IDX_ADDR);
  assert_rd_port_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_rd_o |-> io_addr_o == DAT_ADDR);
  assert_flags_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(present_o && absent_o));
  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_decided_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (present_o != absent_o));
  assert_present_at_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(present_o) |-> done_o);
  assert_start_ignored_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_o && start_i && !io_wr_o && !io_rd_o |=> !io_wr_o);
endmodule

bind probe_seq probe_seq_chk #(
  .ADDR_W   (ADDR_W),
  .IDX_ADDR (IDX_ADDR),
  .DAT_ADDR (DAT_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .io_addr_o  (io_addr_o),
  .io_wdata_o (io_wdata_o),
  .io_wr_o    (io_wr_o),
  .io_rd_o    (io_rd_o),
  .io_rdy_i   (io_rdy_i),
  .present_o  (present_o),
  .absent_o   (absent_o),
  .done_o     (done_o)
);

// File: tb/probe_seq_tb.sv
module probe_seq_tb;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [15:0] base;
    logic [31:0] ver;
    logic [31:0] ven;
    logic [1:0]  lat;
    logic        pres;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{16'h0A40, 32'h00020101, 32'h54524F41, 2'd0, 1'b1},
    '{16'h1234, 32'h000000FF, 32'h11223344, 2'd1, 1'b0},
    '{16'hBEEF, 32'h01020304, 32'h556677FF, 2'd2, 1'b0},
    '{16'hFFFF, 32'hFFFFFFFF, 32'hFFFFFFFF, 2'd3, 1'b0},
    '{16'h00C8, 32'hFF000001, 32'hFFFFFF10, 2'd1, 1'b1}
  };

  logic        clk = 0, rst_n = 0, start = 0;
  logic [15:0] io_addr;
  logic [7:0]  io_wdata, io_rdata;
  logic        io_wr, io_rd, io_rdy;
  logic [15:0] base_addr;
  logic [31:0] version, vendor;
  logic        present, absent, done;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [7:0] mem [16];
  logic [7:0] ridx;
  logic [7:0] wlog [64];
  int nlog = 0, port_err = 0, lat = 0, cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  probe_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .io_addr_o(io_addr), .io_wdata_o(io_wdata), .io_wr_o(io_wr), .io_rd_o(io_rd),
    .io_rdata_i(io_rdata), .io_rdy_i(io_rdy),
    .base_addr_o(base_addr), .version_o(version), .vendor_o(vendor),
    .present_o(present), .absent_o(absent), .done_o(done)
  );

  // responder: index latch + data port with programmable wait states
  initial begin
    io_rdy = 0; io_rdata = 0; ridx = 0;
    forever begin
      @(negedge clk);
      if (!rst_n || io_rdy) begin
        io_rdy = 0; cnt = 0;
      end else if (io_wr || io_rd) begin
        if (cnt >= lat) begin
          io_rdy = 1;
          if (io_wr) begin
            if (io_addr != 16'h004E) port_err++;
            ridx = io_wdata;
            if (nlog < 64) wlog[nlog] = io_wdata;
            nlog++;
          end else if (io_addr != 16'h004F) port_err++;
        end else cnt++;
      end
      io_rdata = mem[ridx[3:0]];
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load(input vec_t v);
    mem[8] = v.base[7:0];
    mem[9] = v.base[15:8];
    for (int k = 0; k < 4; k++) begin
      mem[k]   = v.ver[8*k +: 8];
      mem[4+k] = v.ven[8*k +: 8];
    end
    lat = int'(v.lat);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_done(output bit seen);
    seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      if (done) seen = 1;
      else @(negedge clk);
    end
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    bit seen;
    int first;
    first = nlog;
    load(v);
    pulse_start();
    wait_done(seen);
    check(seen, {tag, " R7 done"}, 32'(seen), 1);
    check(present == v.pres, {tag, " R6 present"}, 32'(present), 32'(v.pres));
    check(absent == !v.pres, {tag, " R6 absent"}, 32'(absent), 32'(!v.pres));
    check(base_addr == v.base, {tag, " R3 base"}, 32'(base_addr), 32'(v.base));
    check(version == v.ver, {tag, " R4 version"}, version, v.ver);
    check(vendor == v.ven, {tag, " R5 vendor"}, vendor, v.ven);
    check(nlog - first == 10, {tag, " R1 write count"}, 32'(nlog - first), 10);
    for (int k = 0; k < 10; k++) begin
      logic [7:0] e;
      e = (k < 2) ? 8'(k + 8) : 8'(k - 2);
      if (first + k < 64)
        check(wlog[first+k] == e, {tag, " R1 index order"}, 32'(wlog[first+k]), 32'(e));
    end
    check(port_err == 0, {tag, " R1 port address"}, 32'(port_err), 0);
    @(negedge clk);
    check(done == 0, {tag, " R7 done single"}, 32'(done), 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R10: outputs cleared while in reset
    check(base_addr == 0 && version == 0 && vendor == 0, "R10 reset values", version, 0);
    check(!present && !absent && !done && !io_wr && !io_rd, "R10 reset flags", 32'(present), 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      run_vec(VECS[v], $sformatf("vec%0d", v));
    end

    // R8: present, second start ignored
    begin
      int snap;
      snap = nlog;
      load(VECS[1]);
      pulse_start();
      repeat (30) @(negedge clk);
      check(nlog == snap, "R8 no bus access", 32'(nlog - snap), 0);
      check(present && !absent, "R8 flags kept", 32'(present), 1);
      check(vendor == VECS[4].ven && base_addr == VECS[4].base, "R8 values kept", vendor, VECS[4].ven);
    end

    // R10: reset after success clears everything
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(base_addr == 0 && version == 0 && vendor == 0, "R10 clear values", 32'(base_addr), 0);
    check(!present && !absent, "R10 clear flags", 32'(present), 0);
    rst_n = 1;

    // R9: failure then retry without reset
    run_vec(VECS[2], "retry_a");
    load(VECS[0]);
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    check(absent == 0, "R9 absent cleared at start", 32'(absent), 0);
    begin
      bit seen;
      wait_done(seen);
      check(seen && present && !absent, "R9 retry present", 32'(present), 1);
      check(version == VECS[0].ver, "R9 retry version", version, VECS[0].ver);
    end

    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule